// File: doc/BRIEF.md
# Rail Fault Monitor And Reporter

This block watches the health of a small set of power rails and the die temperature. It produces one combined fault indication and one request for a forced thermal shutdown. Each rail supplies a digitized under-voltage flag, which the analog comparator raises when the rail output sinks below 68% of its target, and an enable status. Two temperature flags arrive as well: a warning tier near 145 °C and a critical tier near 155 °C. A soft-start-in-progress flag and a global shutdown flag complete the inputs. Every input is asynchronous to the block clock and passes through a two-stage synchronizer before any logic uses it.

The fault output only reports. It never switches off a rail or latches anything off. An under-voltage flag counts only when its rail is enabled and no soft-start ramp is running. The temperature warning sets the fault output and lets operation continue. While the shutdown flag is high, the fault output is held low. A critical temperature drives the shutdown request to the power sequencer.

The shutdown request comes from a three-state machine:
- RUN: no request.
- HOT: critical flag present, request held.
- COOL: critical flag gone, request still held, waiting for a fresh soft-start.

The transitions are:
- RUN→HOT when the critical flag is seen.
- HOT→COOL when the critical flag clears.
- COOL→HOT if the critical flag returns.
- COOL→RUN on a rising edge of the soft-start flag.

Top module: `rail_fault_mon`

## Requirements
- R1: After reset, `fault_o` and `therm_off_o` are both 0.
- R2: `fault_o` equals the OR of (`uv_raw[i]` AND `rail_en[i]`) over all rails, with the under-voltage part gated off while `ramp_busy` is 1, ORed with `ot_warn`, and the whole forced to 0 while `shdn_req` is 1.
- R3: An under-voltage flag on a rail whose `rail_en` bit is 0 has no effect on `fault_o`.
- R4: While `ramp_busy` is 1, under-voltage flags have no effect on `fault_o`. The temperature warning is still reported.
- R5: While `shdn_req` is 1, `fault_o` is 0 whatever the other inputs are.
- R6: `ot_warn` alone sets `fault_o` to 1 and leaves `therm_off_o` at 0.
- R7: `ot_crit` at 1 sets `therm_off_o` to 1 (state RUN→HOT), and it stays 1 while `ot_crit` stays 1.
- R8: After `ot_crit` clears, `therm_off_o` stays 1 (state COOL) until `ramp_busy` rises from 0 to 1. A soft-start rise seen while `ot_crit` is still 1 does not release the request.
- R9: If `ramp_busy` is already 1 when `ot_crit` clears, the request is not released until `ramp_busy` has gone to 0 and then back to 1.
- R10: Under-voltage flags, `shdn_req` and `ot_warn` never set `therm_off_o`.
- R11: A change on any input reaches the outputs on the third rising clock edge after it: two synchronizer stages plus one state or output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_raw | input | NRAILS | Per-rail under-voltage flag from the comparators, asynchronous |
| rail_en | input | NRAILS | Per-rail enable status, asynchronous |
| ramp_busy | input | 1 | Soft-start ramp in progress, asynchronous |
| shdn_req | input | 1 | Global shutdown active, asynchronous |
| ot_warn | input | 1 | Die temperature above the warning level, asynchronous |
| ot_crit | input | 1 | Die temperature above the critical level, asynchronous |
| fault_o | output | 1 | Combined report-only fault flag |
| therm_off_o | output | 1 | Forced thermal shutdown request to the sequencer |

## Verification
The assertions assume that each input flag holds a level for at least one clock once it has passed the synchronizer. They also assume that a critical-temperature event is always accompanied by a soft-start cycle that the sequencer starts later. The bench changes inputs only on falling clock edges and holds each pattern for several cycles. It sweeps every combination of under-voltage, enable, ramp, shutdown and warning with the critical flag low. Soft-start edges are applied only in orders that a real sequencer could produce.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
    typedef enum logic [1:0] {
        TH_RUN  = 2'd0,
        TH_HOT  = 2'd1,
        TH_COOL = 2'd2
    } therm_state_t;
endpackage

// File: rtl/rfm_sync.sv
module rfm_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/rfm_fault_agg.sv
module rfm_fault_agg #(
    parameter int NRAILS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NRAILS-1:0] uv_s,
    input  logic [NRAILS-1:0] en_s,
    input  logic              ramp_s,
    input  logic              shdn_s,
    input  logic              warn_s,
    output logic              fault_o
);
    logic [NRAILS-1:0] uv_live;
    logic              any_uv;
    logic              fault_d;
    logic              fault_q;

    // Per-rail qualification: a rail only counts when enabled and not ramping
    generate
        for (genvar r = 0; r < NRAILS; r++) begin : g_rail
            assign uv_live[r] = uv_s[r] & en_s[r] & ~ramp_s;
        end
    endgenerate

    assign any_uv = |uv_live;

    always_comb begin
        fault_d = 1'b0;
        if (!shdn_s) fault_d = any_uv | warn_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= fault_d;
    end

    assign fault_o = fault_q;

    // R5
    shdn_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_s |=> !fault_o);

    // R6
    warn_reported_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_s && !shdn_s) |=> fault_o);

    // R4
    ramp_masks_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_s && !warn_s) |=> !fault_o);

    // R3
    disabled_rails_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_s == '0) && !warn_s) |=> !fault_o);
endmodule

// File: rtl/rfm_therm_fsm.sv
module rfm_therm_fsm
    import rfm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic crit_s,
    input  logic ramp_s,
    output logic therm_off_o
);
    therm_state_t state_q, state_d;
    logic         ramp_prev_q;
    logic         ramp_rise;

    assign ramp_rise = ramp_s & ~ramp_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ramp_prev_q <= 1'b0;
        else        ramp_prev_q <= ramp_s;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TH_RUN:  if (crit_s) state_d = TH_HOT;
            TH_HOT:  if (!crit_s) state_d = TH_COOL;
            TH_COOL: begin
                if (crit_s)         state_d = TH_HOT;
                else if (ramp_rise) state_d = TH_RUN;
            end
            default: state_d = TH_HOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TH_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        therm_off_o = 1'b1;
        unique case (state_q)
            TH_RUN:  therm_off_o = 1'b0;
            TH_HOT:  therm_off_o = 1'b1;
            TH_COOL: therm_off_o = 1'b1;
            default: therm_off_o = 1'b1;
        endcase
    end

    // R7
    crit_trips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crit_s |=> therm_off_o);

    // R8
    release_needs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(therm_off_o) |-> ($past(ramp_rise) && !$past(crit_s)));

    // R10
    no_spurious_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!therm_off_o && !crit_s) |=> !therm_off_o);
endmodule

// File: rtl/rail_fault_mon.sv
module rail_fault_mon #(
    parameter int NRAILS      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NRAILS-1:0] uv_raw,
    input  logic [NRAILS-1:0] rail_en,
    input  logic              ramp_busy,
    input  logic              shdn_req,
    input  logic              ot_warn,
    input  logic              ot_crit,
    output logic              fault_o,
    output logic              therm_off_o
);
    localparam int SW = 2 * NRAILS + 4;

    logic [SW-1:0]     raw_bus;
    logic [SW-1:0]     syn_bus;
    logic [NRAILS-1:0] uv_s, en_s;
    logic              ramp_s, shdn_s, warn_s, crit_s;

    assign raw_bus = {ot_crit, ot_warn, shdn_req, ramp_busy, rail_en, uv_raw};

    rfm_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_bus),
        .sync_o  (syn_bus)
    );

    assign uv_s   = syn_bus[NRAILS-1:0];
    assign en_s   = syn_bus[2*NRAILS-1:NRAILS];
    assign ramp_s = syn_bus[2*NRAILS];
    assign shdn_s = syn_bus[2*NRAILS+1];
    assign warn_s = syn_bus[2*NRAILS+2];
    assign crit_s = syn_bus[2*NRAILS+3];

    rfm_fault_agg #(.NRAILS(NRAILS)) u_agg (
        .clk     (clk),
        .rst_n   (rst_n),
        .uv_s    (uv_s),
        .en_s    (en_s),
        .ramp_s  (ramp_s),
        .shdn_s  (shdn_s),
        .warn_s  (warn_s),
        .fault_o (fault_o)
    );

    rfm_therm_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .crit_s      (crit_s),
        .ramp_s      (ramp_s),
        .therm_off_o (therm_off_o)
    );
endmodule

// File: tb/rail_fault_mon_bench.sv
module rail_fault_mon_bench;
    localparam int  NR     = 3;
    localparam time CLK_P  = 10ns;
    localparam int  LAT    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] uv_raw = '0, rail_en = '0;
    logic          ramp_busy = 1'b0, shdn_req = 1'b0, ot_warn = 1'b0, ot_crit = 1'b0;
    logic          fault_o, therm_off_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rail_fault_mon #(.NRAILS(NR), .SYNC_STAGES(2)) u_rail_fault_mon (
        .clk(clk), .rst_n(rst_n), .uv_raw(uv_raw), .rail_en(rail_en),
        .ramp_busy(ramp_busy), .shdn_req(shdn_req), .ot_warn(ot_warn),
        .ot_crit(ot_crit), .fault_o(fault_o), .therm_off_o(therm_off_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 fault reset", fault_o, 1'b0);
        chk("R1 therm reset", therm_off_o, 1'b0);
        rst_n = 1'b1;
        settle(LAT);
        chk("R1 fault after release", fault_o, 1'b0);

        // R11: latency of exactly three edges
        ot_warn = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11 not yet at edge 2", fault_o, 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk("R11 visible at edge 3", fault_o, 1'b1);
        chk("R6 warn no shutdown", therm_off_o, 1'b0);
        ot_warn = 1'b0;
        settle(LAT);

        // R2 R3 R4 R5 R6 R10: exhaustive sweep with the critical flag low
        for (int v = 0; v < 512; v++) begin
            logic [NR-1:0] u, e;
            logic rb, sd, wn, exp_f;
            u  = v[2:0];
            e  = v[5:3];
            rb = v[6];
            sd = v[7];
            wn = v[8];
            uv_raw = u; rail_en = e; ramp_busy = rb; shdn_req = sd; ot_warn = wn;
            exp_f = !sd && (((u & e) != 0 && !rb) || wn);
            settle(LAT);
            if (sd)                   chk("R5 shutdown forces low", fault_o, exp_f);
            else if (rb)              chk("R4 ramp masks uv", fault_o, exp_f);
            else if ((u & ~e) != 0 && (u & e) == 0 && !wn)
                                      chk("R3 disabled rail ignored", fault_o, exp_f);
            else                      chk("R2 fault aggregate", fault_o, exp_f);
            chk("R10 no thermal trip", therm_off_o, 1'b0);
        end
        uv_raw = '0; rail_en = '0; ramp_busy = 1'b0; shdn_req = 1'b0; ot_warn = 1'b0;
        settle(LAT);

        // R7: critical trip
        ot_crit = 1'b1;
        settle(LAT);
        chk("R7 crit trips", therm_off_o, 1'b1);
        chk("R2 crit alone no fault", fault_o, 1'b0);
        // R8: ramp rise while still hot is no release
        ramp_busy = 1'b1; settle(LAT);
        ramp_busy = 1'b0; settle(LAT);
        chk("R8 rise while hot", therm_off_o, 1'b1);
        ot_crit = 1'b0;
        settle(LAT + 4);
        chk("R8 cooled waits", therm_off_o, 1'b1);
        ramp_busy = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8 held before edge 3", therm_off_o, 1'b1);
        @(posedge clk);
        @(negedge clk);
        chk("R8 released by restart", therm_off_o, 1'b0);
        ramp_busy = 1'b0;
        settle(LAT);

        // R9: ramp already high when cooled
        ramp_busy = 1'b1; settle(LAT);
        ot_crit = 1'b1; settle(LAT);
        chk("R7 trip with ramp high", therm_off_o, 1'b1);
        ot_crit = 1'b0; settle(LAT + 4);
        chk("R9 level ramp no release", therm_off_o, 1'b1);
        ramp_busy = 1'b0; settle(LAT);
        chk("R9 ramp fall no release", therm_off_o, 1'b1);
        ramp_busy = 1'b1; settle(LAT);
        chk("R9 fresh rise releases", therm_off_o, 1'b0);

        // R7: crit returning while cooling re-arms
        ot_crit = 1'b1; settle(LAT);
        ot_crit = 1'b0; settle(LAT);
        ot_crit = 1'b1; ramp_busy = 1'b0; settle(LAT);
        ramp_busy = 1'b1; settle(LAT);
        chk("R7 held while crit", therm_off_o, 1'b1);
        ot_crit = 1'b0; ramp_busy = 1'b0; settle(LAT);
        ramp_busy = 1'b1; settle(LAT);
        chk("R8 release after re-arm", therm_off_o, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule